// File: doc/BRIEF.md
# CMI line codec with test loopbacks

This block holds one code-mark-inversion (CMI) transmit encoder and one CMI receive decoder. Each has its own clock at twice the bit rate. Two control inputs choose how the data paths connect. With both controls low, the transmit and receive directions are unrelated. The transmitter turns each binary bit into a pair of line half-bits. The receiver turns each pair of received half-bits back into one binary bit. Each direction gives out its own clock divided by two.

Raising the binary-loopback control does three things. The transmit binary input goes back out on the receive binary output. The transmit divided clock goes out on the receive clock output. The line output sends the alarm pattern, an endless run of encoded ones. Raising the line-loopback control decodes the received line, encodes it again with a second encoder clocked by the receive clock, and sends the result on the line output. If both controls are high, each output takes the loopback path that feeds it.

One active-low reset is sampled on both clocks. After reset, every half-bit pair is aligned to the first clock edge that sees the reset released.

Top module: `cmi_loop_codec`

## Requirements
- R1: While rst_n is low at a clock edge, tx_line_o, tx_clk_o, rx_bin_o and rx_clk_o are 0 after that edge.
- R2: tx_clk_o and rx_clk_o toggle on every edge of their own clock after reset. Each is 1 after edge 0, where edge 0 is the first edge at which rst_n is high.
- R3: The line code maps a 0 to the pair (low, high) and a 1 to (low, low) or (high, high), alternating between the two. The first 1 after reset is sent as (low, low).
- R4: tx_bin_i is sampled at even edges 2j. The first half of its pair shows on tx_line_o after edge 2j+3 and the second half after edge 2j+4.
- R5: rx_line_i is taken in pairs: the first half at even edge 2j, the second at edge 2j+1. A pair with equal halves decodes as 1. Every other pair, including (high, low), decodes as 0.
- R6: Outside binary loopback, the bit decoded from the pair starting at edge 2j shows on rx_bin_o after edge 2j+4 and holds for two cycles.
- R7: In binary loopback, rx_bin_o gives tx_bin_i sampled at edge 2j after edge 2j+3 (3 transmit cycles), and rx_clk_o follows tx_clk_o.
- R8: In binary loopback without line loopback, tx_line_o sends encoded ones (alternating (low, low) and (high, high)) whatever tx_bin_i is.
- R9: In line loopback, the bit decoded from the pair starting at receive edge 2j is encoded again. It uses its own alternation, which starts at (low, low) after reset. Its first half shows on tx_line_o after receive edge 2j+5.
- R10: With both loopbacks high, rx_bin_o follows R7 and tx_line_o follows R9.
- R11: With both loopbacks low, tx_line_o depends only on tx_bin_i and rx_bin_o depends only on rx_line_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit clock, twice the bit rate |
| clk_rx | input | 1 | Receive clock, twice the bit rate |
| rst_n | input | 1 | Active-low reset, synchronous to each clock |
| lpbk_bin_i | input | 1 | Binary loopback control |
| lpbk_line_i | input | 1 | Line loopback control |
| tx_bin_i | input | 1 | Binary data to encode |
| tx_line_o | output | 1 | Encoded line half-bits |
| tx_clk_o | output | 1 | Transmit clock divided by two |
| rx_line_i | input | 1 | Received line half-bits |
| rx_bin_o | output | 1 | Decoded binary data |
| rx_clk_o | output | 1 | Receive clock divided by two, or the transmit one in binary loopback |

## Verification
A half-rate phase flop that goes wrong swaps the two halves of every pair. This shows on tx_line_o within four cycles as (high, low) pairs for zeros, and as decoded bits built from halves of two neighbouring pairs. An alternation flop that is wrong inverts every pair of ones from the first 1 on. A pipeline stage that is wrong shifts the whole stream by a whole cycle, which breaks the fixed latencies of 3, 4 and 5 cycles at the very first bit after reset. The sweeps cover every half-bit pair value, in all four control settings, against a model that computes each expected half-bit from the cycle index.

// File: rtl/cmi_pkg.sv
// Package: shared types and the pair-encoding rule for the CMI codec.
// Assumes a pair is sent high-index half first.
package cmi_pkg;
    typedef logic [1:0] cmi_pair_t;

    // pair sent for a binary zero: first half low, second high
    localparam cmi_pair_t CMI_PAIR_ZERO = 2'b01;
    // cycles from capture to first line half / decoded bit
    localparam int CMI_TX_LAT   = 3;
    localparam int CMI_RX_LAT   = 4;

    // Encode one bit given the current alternation level for ones.
    function automatic cmi_pair_t cmi_encode(input logic b, input logic level);
        return b ? {level, level} : CMI_PAIR_ZERO;
    endfunction
endpackage

// File: rtl/cmi_halfrate.sv
// Half-rate phase generator: toggles each clock after reset.
// Value 0 before an edge marks that edge as the first half of a bit period.
module cmi_halfrate (
    input  logic clk,
    input  logic rst_n,
    output logic ph
);
    // toggle the phase every cycle, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end
endmodule

// File: rtl/cmi_encoder.sv
// CMI encoder: samples a bit at even edges, builds its pair one edge
// later, and shifts the halves out with a latency of three cycles.
// Assumes ph comes from cmi_halfrate on the same clock.
module cmi_encoder
    import cmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic bit_i,
    output logic line_o
);
    logic      bit_q;
    logic      level_q;
    cmi_pair_t pair_q;
    cmi_pair_t pair_d;

    // capture the bit, build the pair, serialize the halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            level_q <= 1'b0;
            pair_q  <= '0;
            pair_d  <= '0;
            line_o  <= 1'b0;
        end else begin
            if (!ph) begin
                bit_q  <= bit_i;
                pair_d <= pair_q;
            end else begin
                pair_q <= cmi_encode(bit_q, level_q);
                if (bit_q) level_q <= ~level_q;
            end
            line_o <= ph ? pair_d[1] : pair_d[0];
        end
    end
endmodule

// File: rtl/cmi_decoder.sv
// CMI decoder: takes the first half at even edges and the second at odd
// edges, decides equal halves = 1, and presents the bit four cycles
// after the first half was taken. bit_o is the early decision for reuse.
module cmi_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic line_i,
    output logic bit_o,
    output logic bin_o
);
    logic half_q;
    logic pipe_q;

    // hold first half, decide on second, delay to the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            bit_o  <= 1'b0;
            pipe_q <= 1'b0;
            bin_o  <= 1'b0;
        end else if (!ph) begin
            half_q <= line_i;
            pipe_q <= bit_o;
            bin_o  <= pipe_q;
        end else begin
            bit_o  <= (half_q == line_i);
        end
    end
endmodule

// File: rtl/cmi_bin_echo.sv
// Binary echo line: returns the transmit bit three transmit cycles after
// its even-edge capture. Assumes ph from the transmit phase generator.
module cmi_bin_echo (
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic bin_i,
    output logic bin_o
);
    logic cap_q;
    logic mid_q;

    // capture on even edges, shift out on odd edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            mid_q <= 1'b0;
            bin_o <= 1'b0;
        end else if (!ph) begin
            cap_q <= bin_i;
        end else begin
            mid_q <= cap_q;
            bin_o <= mid_q;
        end
    end
endmodule

// File: rtl/cmi_loop_codec.sv
// CMI codec top: transmit encoder, receive decoder, binary echo and a
// second encoder on the receive clock for line loopback. The controls
// select the paths with combinational muxes. Binary loopback owns the
// receive outputs, line loopback owns the line output.
// Assumes both clocks run at twice the bit rate and controls are quasi-static.
module cmi_loop_codec (
    input  logic clk_tx,
    input  logic clk_rx,
    input  logic rst_n,
    input  logic lpbk_bin_i,
    input  logic lpbk_line_i,
    input  logic tx_bin_i,
    output logic tx_line_o,
    output logic tx_clk_o,
    input  logic rx_line_i,
    output logic rx_bin_o,
    output logic rx_clk_o
);
    logic tx_ph;
    logic rx_ph;
    logic enc_bit;
    logic enc_line;
    logic loop_line;
    logic dec_bit;
    logic dec_bin;
    logic echo_bin;

    cmi_halfrate u_tx_ph (.clk(clk_tx), .rst_n(rst_n), .ph(tx_ph));
    cmi_halfrate u_rx_ph (.clk(clk_rx), .rst_n(rst_n), .ph(rx_ph));

    // alarm: force encoded ones while the binary input is echoed
    always_comb enc_bit = lpbk_bin_i | tx_bin_i;

    cmi_encoder u_enc (
        .clk(clk_tx), .rst_n(rst_n), .ph(tx_ph),
        .bit_i(enc_bit), .line_o(enc_line)
    );

    cmi_decoder u_dec (
        .clk(clk_rx), .rst_n(rst_n), .ph(rx_ph),
        .line_i(rx_line_i), .bit_o(dec_bit), .bin_o(dec_bin)
    );

    cmi_encoder u_loop_enc (
        .clk(clk_rx), .rst_n(rst_n), .ph(rx_ph),
        .bit_i(dec_bit), .line_o(loop_line)
    );

    cmi_bin_echo u_echo (
        .clk(clk_tx), .rst_n(rst_n), .ph(tx_ph),
        .bin_i(tx_bin_i), .bin_o(echo_bin)
    );

    // output path selection
    always_comb begin
        tx_line_o = lpbk_line_i ? loop_line : enc_line;
        rx_bin_o  = lpbk_bin_i  ? echo_bin  : dec_bin;
        rx_clk_o  = lpbk_bin_i  ? tx_ph     : rx_ph;
        tx_clk_o  = tx_ph;
    end
endmodule

// File: rtl/cmi_loop_codec_chk.sv
// Checker for cmi_loop_codec: reset, clock division, alarm pairs, echo
// latency and decoder hold. Bound to every instance of the top.
module cmi_loop_codec_chk (
    input logic clk_tx,
    input logic clk_rx,
    input logic rst_n,
    input logic lpbk_bin_i,
    input logic lpbk_line_i,
    input logic tx_bin_i,
    input logic tx_line_o,
    input logic tx_clk_o,
    input logic rx_bin_o,
    input logic rx_clk_o,
    input logic tx_ph,
    input logic rx_ph
);
    AST_RESET_TX: assert property (@(posedge clk_tx) !rst_n |=> (tx_line_o == 1'b0 && tx_clk_o == 1'b0)); // R1
    AST_RESET_RX: assert property (@(posedge clk_rx) !rst_n |=> (rx_bin_o == 1'b0 && rx_clk_o == 1'b0)); // R1
    AST_TX_CLK_TOGGLE: assert property (@(posedge clk_tx) disable iff (!rst_n) 1'b1 |=> tx_clk_o != $past(tx_clk_o)); // R2
    AST_ALARM_PAIR: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (!tx_ph && !lpbk_line_i && $past(lpbk_bin_i, 4) && $past(rst_n, 4) && $past(rst_n, 3)
         && $past(rst_n, 2) && $past(rst_n, 1))
        |=> (lpbk_line_i || tx_line_o == $past(tx_line_o))); // R8
    AST_ECHO_LATENCY: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (tx_ph && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1))
        |=> (!lpbk_bin_i || rx_bin_o == $past(tx_bin_i, 4))); // R7
    AST_RX_HOLD: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (rx_ph && !lpbk_bin_i) |=> (lpbk_bin_i || $stable(rx_bin_o))); // R6
endmodule

bind cmi_loop_codec cmi_loop_codec_chk u_chk (
    .clk_tx(clk_tx), .clk_rx(clk_rx), .rst_n(rst_n),
    .lpbk_bin_i(lpbk_bin_i), .lpbk_line_i(lpbk_line_i), .tx_bin_i(tx_bin_i),
    .tx_line_o(tx_line_o), .tx_clk_o(tx_clk_o), .rx_bin_o(rx_bin_o),
    .rx_clk_o(rx_clk_o), .tx_ph(tx_ph), .rx_ph(rx_ph)
);

// File: tb/sim_cmi_loop_codec.sv
// Bench: both clocks come from one 250 MHz clock. The sweep covers the
// four control settings and several seeds. Expected half-bits are
// computed from the cycle index since reset release.
module sim_cmi_loop_codec;
    localparam int NB = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic lb = 1'b0;
    logic ll = 1'b0;
    logic bin = 1'b0;
    logic line = 1'b0;
    logic tx_line, tx_clk, rx_bin, rx_clk;
    int checks = 0;
    int errors = 0;

    cmi_loop_codec u0 (
        .clk_tx(clk), .clk_rx(clk), .rst_n(rst_n),
        .lpbk_bin_i(lb), .lpbk_line_i(ll), .tx_bin_i(bin),
        .tx_line_o(tx_line), .tx_clk_o(tx_clk),
        .rx_line_i(line), .rx_bin_o(rx_bin), .rx_clk_o(rx_clk)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", tag, n, act, exp);
        end
    endtask

    task automatic run_case(input logic mb, input logic mc, input logic [7:0] seed);
        logic       binb [NB];
        logic       lh   [2*NB];
        logic [1:0] mp   [NB];
        logic [1:0] lp   [NB];
        logic       mk  = 1'b0;
        logic       mk2 = 1'b0;
        string      tq, tb;
        int         lat = mc ? 5 : 3;
        for (int j = 0; j < NB; j++) begin
            logic [1:0] p = 2'(j ^ (j >> 2)) ^ seed[1:0];
            logic b, d;
            binb[j] = seed[j % 8];
            lh[2*j] = p[1];
            lh[2*j+1] = p[0];
            b = mb | binb[j];
            mp[j] = b ? {mk, mk} : 2'b01;
            if (b) mk = ~mk;
            d = (p[1] == p[0]);
            lp[j] = d ? {mk2, mk2} : 2'b01;
            if (d) mk2 = ~mk2;
        end
        tq = mc ? (mb ? "R10 R9" : "R9 R5") : (mb ? "R8" : "R3 R4 R11");
        tb = mb ? (mc ? "R10 R7" : "R7") : "R5 R6 R11";
        // reset for three edges, all outputs low (R1)
        @(negedge clk);
        rst_n = 1'b0; lb = mb; ll = mc; bin = 1'b0; line = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_line, 1'b0, "R1", -1);
        chk(tx_clk, 1'b0, "R1", -1);
        chk(rx_bin, 1'b0, "R1", -1);
        chk(rx_clk, 1'b0, "R1", -1);
        rst_n = 1'b1;
        for (int n = 0; n < 2*NB; n++) begin
            bin = binb[n/2];
            line = lh[n];
            @(negedge clk);
            // line output: pair halves per R3/R4, alarm R8, loopback R9
            if (n >= lat) begin
                logic [1:0] pr = mc ? lp[(n-lat)/2] : mp[(n-lat)/2];
                chk(tx_line, ((n-lat) % 2 == 0) ? pr[1] : pr[0], tq, n);
            end else if (!mc) begin
                chk(tx_line, 1'b0, tq, n);
            end
            // binary output: echo R7 or decode R5/R6
            if (mb) begin
                chk(rx_bin, (n >= 3) ? binb[(n-3)/2] : 1'b0, tb, n);
            end else begin
                int j = (n - 4) / 2;
                chk(rx_bin, (n >= 4) ? (lh[2*j] == lh[2*j+1]) : 1'b0, tb, n);
            end
            // divided clocks (R2)
            chk(tx_clk, logic'((n + 1) % 2), "R2", n);
            chk(rx_clk, logic'((n + 1) % 2), "R2", n);
        end
        // reset in the middle of traffic clears outputs after one edge (R1)
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_line, 1'b0, "R1", 2*NB);
        chk(rx_bin, 1'b0, "R1", 2*NB);
        chk(rx_clk, 1'b0, "R1", 2*NB);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] seeds [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                run_case(m[0], m[1], seeds[s]);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule